// File: doc/BRIEF.md
# Two-Lane Pixel Word Serializer

This block turns a stream of 14-bit pixel words into two single-bit serial lanes running at seven times the pixel rate. The upper half of each word leaves on one lane and the lower half on the other, most significant bit first. A pixel-rate frame marker and a mid-bit clock line travel with the data, so a receiver can find word boundaries and sample each bit in the middle of its slot.

Everything runs on one clock. The host supplies a slot strobe that marks the start of each bit slot and a middle strobe placed halfway through each slot. The frame marker stays high for two or three slots depending on pixel parity, and the receiver uses this to tell even pixels from odd ones. On the last slot of each word the block takes the next word from its input. If no word is marked valid at that moment, the lanes carry zeros and the frame marker keeps its normal cadence.

Top module: `pixel_lane_serializer`

## Requirements
- R1: A synchronous active-high reset makes both lanes 0, the bit clock 0 and the frame marker 1 (slot 0 of an odd pixel) on the first sampling after the reset edge.
- R2: `laneData[1]` carries word bits 13 down to 7, one bit per slot, with bit 13 in slot 0.
- R3: `laneData[0]` carries word bits 6 down to 0, one bit per slot, with bit 6 in slot 0.
- R4: A new word is taken on the slot strobe of slot 6 when `inValid` is 1. If `inValid` is 0 there, the next pixel's lanes are all zeros.
- R5: The frame marker is high in slot 0 of every pixel, the slot whose lanes carry bits 13 and 6.
- R6: For an odd pixel the frame marker is high in slots 0 to 2 and falls at the start of slot 3 (bits 10 and 3).
- R7: For an even pixel the frame marker is high in slots 0 and 1 and falls at the start of slot 2 (bits 11 and 4).
- R8: The pixel after reset is odd. Parity toggles on every slot-6 strobe, whether or not the word there is valid.
- R9: `bitClk` toggles once on each middle strobe and changes at no other time.
- R10: When the slot strobe is low, the lanes and the frame marker hold their values.
- R11: Every pixel spans exactly 7 slots, numbered 0 to 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock |
| rst | input | 1 | Synchronous active-high reset |
| bitEn | input | 1 | Start-of-slot strobe |
| midEn | input | 1 | Middle-of-slot strobe |
| inWord | input | 14 | Pixel word to send next |
| inValid | input | 1 | inWord is valid at the slot-6 strobe |
| laneData | output | 2 | Serial lanes: bit 1 upper half, bit 0 lower half |
| frame | output | 1 | Pixel-rate frame marker |
| bitClk | output | 1 | Bit clock that toggles in the middle of each slot |

## Verification
The hardest state to reach is a reset that arrives partway through a word. After it, the parity must restart at odd and the slot count at zero, even though the datapath was holding a half-shifted word. The stimulus drives a known word a few slots in, asserts reset for one clock, and then steps the slots one at a time. It checks that the lanes clear and that the frame marker stays high through slot 2, which is the odd pattern. Idle pixels placed between valid words show that parity keeps advancing with no valid word present.

// File: rtl/pixel_lane_pkg.sv
package pixel_lane_pkg;
  // Strobes from the slot control to the lane datapath
  typedef struct packed {
    logic load;   // take a new word (last slot boundary)
    logic shift;  // advance each lane by one bit
  } laneCtl_t;
endpackage

// File: rtl/pixel_lane_ctrl.sv
module pixel_lane_ctrl
  import pixel_lane_pkg::*;
#(
  parameter int SLOTS     = 7,
  parameter int FALL_EVEN = 2,
  parameter int FALL_ODD  = 3
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     bitEn,
  input  logic     midEn,
  output laneCtl_t ctl,
  output logic     frame,
  output logic     bitClk
);
  localparam int CW = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam logic [CW-1:0] LAST_SLOT = CW'(SLOTS - 1);
  localparam logic [CW-1:0] EVEN_END  = CW'(FALL_EVEN);
  localparam logic [CW-1:0] ODD_END   = CW'(FALL_ODD);

  logic [CW-1:0] slotCnt;
  logic          pixOdd;
  logic          lastSlot;

  assign lastSlot = (slotCnt == LAST_SLOT);

  always_ff @(posedge clk) begin
    if (rst) begin
      slotCnt <= '0;
      pixOdd  <= 1'b1;
      bitClk  <= 1'b0;
    end else begin
      if (bitEn) begin
        if (lastSlot) begin
          slotCnt <= '0;
          pixOdd  <= ~pixOdd;
        end else begin
          slotCnt <= slotCnt + 1'b1;
        end
      end
      if (midEn) bitClk <= ~bitClk;
    end
  end

  always_comb begin
    ctl.load  = bitEn & lastSlot;
    ctl.shift = bitEn & ~lastSlot;
    frame     = slotCnt < (pixOdd ? ODD_END : EVEN_END);
  end

  // R11: slot count never leaves 0..SLOTS-1
  p_slot_range_r11: assert property (@(posedge clk) disable iff (rst)
    slotCnt <= LAST_SLOT);
  // R8: parity flips at each pixel boundary
  p_parity_flip_r8: assert property (@(posedge clk) disable iff (rst)
    (bitEn && lastSlot) |=> (pixOdd != $past(pixOdd)));
  // R9: bit clock flips on the middle strobe
  p_clk_toggle_r9: assert property (@(posedge clk) disable iff (rst)
    midEn |=> (bitClk != $past(bitClk)));
  // R9: and holds otherwise
  p_clk_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !midEn |=> $stable(bitClk));
  // R5: frame rises only in slot 0
  p_frame_rise_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(frame) |-> (slotCnt == '0));
  // R6/R7: frame only falls after a slot strobe
  p_frame_fall_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(frame) |-> $past(bitEn));
endmodule

// File: rtl/pixel_lane_dpath.sv
module pixel_lane_dpath
  import pixel_lane_pkg::*;
#(
  parameter int WORD_W = 14,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  laneCtl_t          ctl,
  input  logic [WORD_W-1:0] inWord,
  input  logic              inValid,
  output logic [LANES-1:0]  laneData
);
  localparam int LANE_W = WORD_W / LANES;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] shReg;
    always_ff @(posedge clk) begin
      if (rst) begin
        shReg <= '0;
      end else if (ctl.load) begin
        shReg <= inValid ? inWord[g*LANE_W +: LANE_W] : '0;
      end else if (ctl.shift) begin
        shReg <= {shReg[LANE_W-2:0], 1'b0};
      end
    end
    assign laneData[g] = shReg[LANE_W-1];
  end

  // R4: an empty slot boundary yields zero lanes
  p_idle_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (ctl.load && !inValid) |=> (laneData == '0));
  // R2/R3: a loaded word shows its top bits first
  p_load_msb_r2: assert property (@(posedge clk) disable iff (rst)
    (ctl.load && inValid) |=> (laneData[LANES-1] == $past(inWord[WORD_W-1])));
  // R10: nothing moves without a strobe
  p_lane_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!ctl.load && !ctl.shift) |=> $stable(laneData));
endmodule

// File: rtl/pixel_lane_serializer.sv
module pixel_lane_serializer
  import pixel_lane_pkg::*;
#(
  parameter int WORD_W    = 14,
  parameter int LANES     = 2,
  parameter int FALL_EVEN = 2,
  parameter int FALL_ODD  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bitEn,
  input  logic              midEn,
  input  logic [WORD_W-1:0] inWord,
  input  logic              inValid,
  output logic [LANES-1:0]  laneData,
  output logic              frame,
  output logic              bitClk
);
  localparam int SLOTS = WORD_W / LANES;

  laneCtl_t ctl;

  pixel_lane_ctrl #(
    .SLOTS(SLOTS), .FALL_EVEN(FALL_EVEN), .FALL_ODD(FALL_ODD)
  ) ctrl_i (
    .clk(clk), .rst(rst), .bitEn(bitEn), .midEn(midEn),
    .ctl(ctl), .frame(frame), .bitClk(bitClk)
  );

  pixel_lane_dpath #(
    .WORD_W(WORD_W), .LANES(LANES)
  ) dpath_i (
    .clk(clk), .rst(rst), .ctl(ctl), .inWord(inWord),
    .inValid(inValid), .laneData(laneData)
  );

  // R10: frame marker holds while no slot strobe arrives
  p_frame_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !bitEn |=> $stable(frame));
endmodule

// File: tb/pixel_lane_serializer_tb.sv
module pixel_lane_serializer_tb_top;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst, bitEn, midEn, inValid;
  logic [13:0] inWord;
  logic [1:0]  laneData;
  logic frame, bitClk;
  int total = 0;
  int fails = 0;
  logic expOdd;

  always #(CLK_P/2) clk = ~clk;

  pixel_lane_serializer dut_i (
    .clk(clk), .rst(rst), .bitEn(bitEn), .midEn(midEn),
    .inWord(inWord), .inValid(inValid),
    .laneData(laneData), .frame(frame), .bitClk(bitClk)
  );

  // {valid, word}
  localparam logic [14:0] VECS [0:6] = '{
    {1'b1, 14'h3FFF}, {1'b1, 14'h2AAA}, {1'b0, 14'h1555},
    {1'b1, 14'h2001}, {1'b1, 14'h0080}, {1'b0, 14'h3FFF},
    {1'b1, 14'h1C63}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic expFrame(int k, logic odd);
    return (k < (odd ? 3 : 2));
  endfunction

  // one slot: strobe, middle strobe, idle; starts and ends at a negedge
  task automatic step();
    logic prevClk;
    bitEn = 1'b1;
    @(negedge clk);
    bitEn = 1'b0;
    prevClk = bitClk;
    midEn = 1'b1;
    @(negedge clk);
    midEn = 1'b0;
    chk("R9 toggle", {31'd0, bitClk}, {31'd0, ~prevClk});
    @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 150000);
    fails++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    rst = 1'b1; bitEn = 1'b0; midEn = 1'b0; inValid = 1'b0; inWord = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 lanes", {30'd0, laneData}, 32'd0);
    chk("R1 frame", {31'd0, frame}, 32'd1);
    chk("R1 bitClk", {31'd0, bitClk}, 32'd0);
    // idle odd pixel after reset: R8, R6
    expOdd = 1'b1;
    for (int k = 1; k < 7; k++) begin
      step();
      chk("R8 odd after reset", {31'd0, frame}, {31'd0, expFrame(k, 1'b1)});
      chk("R4 idle lanes", {30'd0, laneData}, 32'd0);
    end
    // vector walk: R2 R3 R4 R5 R6 R7 R8 R11
    for (int v = 0; v < 7; v++) begin
      logic [13:0] w;
      w = VECS[v][14] ? VECS[v][13:0] : 14'd0;
      inWord = VECS[v][13:0];
      inValid = VECS[v][14];
      step();
      inValid = 1'b0; inWord = 14'h0BAD;
      expOdd = ~expOdd;
      for (int k = 0; k < 7; k++) begin
        chk("R2 upper lane", {31'd0, laneData[1]}, {31'd0, w[13-k]});
        chk("R3 lower lane", {31'd0, laneData[0]}, {31'd0, w[6-k]});
        chk(expOdd ? "R6 odd frame" : "R7 even frame",
            {31'd0, frame}, {31'd0, expFrame(k, expOdd)});
        if (k == 0) chk("R5 frame at slot0", {31'd0, frame}, 32'd1);
        if (k == 3) begin
          logic [1:0] hl; logic hf;
          hl = laneData; hf = frame;
          repeat (3) @(negedge clk);
          chk("R10 lanes hold", {30'd0, laneData}, {30'd0, hl});
          chk("R10 frame hold", {31'd0, frame}, {31'd0, hf});
        end
        if (k < 6) step();
      end
      // R11: the 7th strobe is the boundary (checked by next latch)
    end
    // R11: after 7 more strobes an idle pixel begins with frame high
    step();
    chk("R11 period", {31'd0, frame}, 32'd1);
    // mid-word reset: R1 R8
    inWord = 14'h3FFF; inValid = 1'b1;
    for (int k = 1; k < 7; k++) step();
    step();
    inValid = 1'b0;
    step(); step();
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 mid reset lanes", {30'd0, laneData}, 32'd0);
    chk("R1 mid reset frame", {31'd0, frame}, 32'd1);
    chk("R1 mid reset bitClk", {31'd0, bitClk}, 32'd0);
    step(); step();
    chk("R8 odd after mid reset", {31'd0, frame}, 32'd1);
    step();
    chk("R6 fall at slot3", {31'd0, frame}, 32'd0);
    chk("R4 zeros after reset", {30'd0, laneData}, 32'd0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule